// File: doc/BRIEF.md
# Fuse Read Chunking Sequencer

This block accepts a request for any byte range of fuse data, given as a start address and a byte count. It breaks the range into pieces that a fuse read controller can serve one at a time. For each piece it writes the controller's control register, polls the status register until the read is done, and fetches the data words. It then sends the bytes out one per cycle, in address order, on a stream with valid and last.

When a piece is finished, the sequencer moves the address forward and starts the next piece, until the count is used up. A piece whose status poll does not finish within a fixed number of reads is abandoned. In that case the request ends with an error flag set and no further bus traffic. The controller is reached through a simple single-outstanding register bus. A request stays on that bus until it is acknowledged.

Top module: `fuse_chunk_seq`

## Requirements
- R1: The piece size is 32 when 32 or more bytes remain, the remaining count rounded down to a multiple of 4 when 4 to 31 remain, and the remaining count itself when 1 to 3 remain.
- R2: Each piece begins with one bus write to offset 0x00. Its data has bit 0 set, bits 20:16 equal to the piece size minus 1, and bits 29:21 equal to the piece's start address.
- R3: After a piece, the address advances by the piece size and the remaining count drops by the same amount. The request ends when the count reaches zero, so the stream carries exactly the requested number of bytes.
- R4: After the control write, the sequencer reads offset 0x04 until bit 0 of the returned data is 1, making at most POLL_LIMIT reads. A bus request is held with a stable address and data until it is acknowledged.
- R5: A piece whose size is a multiple of 4 reads size/4 words at offsets 0x08 + 4*i, with i going upward from 0. Any other piece reads only the word at 0x08.
- R6: The bytes of each word are sent low byte (bits 7:0) first, one per cycle. The whole stream is in ascending fuse address order.
- R7: out_last is high on the final byte of a completed request and on no other byte.
- R8: If POLL_LIMIT status reads all return bit 0 clear, that piece sends no bytes. The sequencer then sets err, pulses done, returns to idle and makes no further bus access.
- R9: A start that arrives while busy is high is ignored, and the running request completes unchanged.
- R10: A request with a count of zero pulses done in the cycle after start, with no bus access and no bytes.
- R11: After reset, busy, done, err, bus_req and out_valid are all low.
- R12: err stays set until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken only while idle |
| req_addr | input | ADDR_W | First fuse byte address |
| req_count | input | CNT_W | Number of bytes to read |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse when a request ends |
| err | output | 1 | The last request timed out |
| bus_req | output | 1 | Register bus access pending |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | BUS_AW | Register byte offset |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access completed this cycle |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| out_valid | output | 1 | out_data holds a fuse byte |
| out_data | output | 8 | Fuse byte |
| out_last | output | 1 | Final byte of the request |

## Verification
Only the zero-count case has a fixed latency. Its done pulse is due one clock after the edge that samples start, so the bench drives start on a falling edge and samples done on the next falling edge. Every other result depends on how many cycles the bench's controller model takes to respond, which varies at random. For those, the bench records each bus access and each output byte on falling edges as they happen. It compares them with its own piece walk only after done, so no check depends on a count of cycles. For ignored starts and timeouts, the bench also checks that bus_req and out_valid stay quiet once done has been seen.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_POLL,
    ST_DATA,
    ST_EMIT
  } seq_state_t;

  localparam int BYTES_PER_WORD = 4;
  localparam int CTRL_LEN_LSB   = 16;
  localparam int CTRL_ADDR_LSB  = 21;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_DATA = 8'h08;

endpackage

// File: rtl/fcs_chunk_calc.sv
module fcs_chunk_calc #(
  parameter int CNT_W     = 10,
  parameter int CHUNK_MAX = 32,
  localparam int WC_W     = $clog2(CHUNK_MAX / 4 + 1)
) (
  input  logic [CNT_W-1:0] rem,
  output logic [CNT_W-1:0] chunk_sz,
  output logic [WC_W-1:0]  word_cnt,
  output logic             is_words
);

  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(CHUNK_MAX);

  // three tiers: full piece, whole words, byte remainder
  always_comb begin
    if (rem >= MAX_C)
      chunk_sz = MAX_C;
    else if (rem >= CNT_W'(4))
      chunk_sz = {rem[CNT_W-1:2], 2'b00};
    else
      chunk_sz = rem;
  end

  assign is_words = (chunk_sz[1:0] == 2'b00);
  assign word_cnt = is_words ? WC_W'(chunk_sz >> 2) : WC_W'(1);

endmodule

// File: rtl/fcs_bus_master.sv
module fcs_bus_master #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_we,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (bus_req && bus_ack) begin
        bus_req   <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_data  <= bus_rdata;
      end else if (cmd_valid && !bus_req) begin
        bus_req   <= 1'b1;
        bus_we    <= cmd_we;
        bus_addr  <= cmd_addr;
        bus_wdata <= cmd_wdata;
      end
    end
  end

endmodule

// File: rtl/fcs_byte_emit.sv
module fcs_byte_emit #(
  parameter int DW = 32,
  localparam int NB = DW / 8,
  localparam int NW = $clog2(NB + 1),
  localparam int IW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_word,
  input  logic [NW-1:0] load_n,
  input  logic          load_final,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_last,
  output logic          drain
);

  logic [DW-1:0] word_q;
  logic [NW-1:0] left_q;
  logic [IW-1:0] idx_q;
  logic          final_q;
  logic [7:0]    lanes [NB];

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lanes[g] = word_q[8*g +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      left_q  <= '0;
      idx_q   <= '0;
      final_q <= 1'b0;
    end else if (load) begin
      word_q  <= load_word;
      left_q  <= load_n;
      idx_q   <= '0;
      final_q <= load_final;
    end else if (left_q != '0) begin
      left_q <= left_q - NW'(1);
      idx_q  <= idx_q + IW'(1);
    end
  end

  assign out_valid = (left_q != '0);
  assign out_data  = lanes[idx_q];
  assign drain     = (left_q == NW'(1));
  assign out_last  = final_q && drain;

endmodule

// File: rtl/fuse_chunk_seq.sv
module fuse_chunk_seq
  import fcs_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int CNT_W      = 10,
  parameter int BUS_AW     = 8,
  parameter int CHUNK_MAX  = 32,
  parameter int POLL_LIMIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_count,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              bus_req,
  output logic              bus_we,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic              bus_ack,
  input  logic [31:0]       bus_rdata,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_last
);

  localparam int WC_W  = $clog2(CHUNK_MAX / 4 + 1);
  localparam int PC_W  = $clog2(POLL_LIMIT + 1);
  localparam int LEN_W = $clog2(CHUNK_MAX);
  localparam int NW    = $clog2(BYTES_PER_WORD + 1);

  seq_state_t        state_q;
  logic              cmd_sent_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  rem_q;
  logic [WC_W-1:0]   word_idx_q;
  logic [PC_W-1:0]   poll_q;
  logic              done_q;
  logic              err_q;

  logic [CNT_W-1:0]  chunk_sz;
  logic [WC_W-1:0]   word_cnt;
  logic              is_words;

  logic              cmd_valid;
  logic              cmd_we;
  logic [BUS_AW-1:0] cmd_addr;
  logic [31:0]       cmd_wdata;
  logic              rsp_valid;
  logic [31:0]       rsp_data;

  logic              emit_load;
  logic [NW-1:0]     emit_n;
  logic              emit_final;
  logic              emit_drain;

  // named events, also watched by the checker
  logic              accept;
  logic              ctrl_issue;
  logic              poll_fail;
  logic              timeout;
  logic              last_word;
  logic              chunk_retire;

  fcs_chunk_calc #(.CNT_W(CNT_W), .CHUNK_MAX(CHUNK_MAX)) u_calc (
    .rem      (rem_q),
    .chunk_sz (chunk_sz),
    .word_cnt (word_cnt),
    .is_words (is_words)
  );

  always_comb begin
    cmd_valid = (state_q == ST_CTRL || state_q == ST_POLL || state_q == ST_DATA) && !cmd_sent_q;
    cmd_we    = (state_q == ST_CTRL);
    cmd_wdata = '0;
    unique case (state_q)
      ST_CTRL: begin
        cmd_addr  = BUS_AW'(OFS_CTRL);
        cmd_wdata[0] = 1'b1;
        cmd_wdata[CTRL_LEN_LSB +: LEN_W]   = LEN_W'(chunk_sz - CNT_W'(1));
        cmd_wdata[CTRL_ADDR_LSB +: ADDR_W] = addr_q;
      end
      ST_POLL: cmd_addr = BUS_AW'(OFS_STAT);
      default: cmd_addr = BUS_AW'(OFS_DATA) + BUS_AW'({word_idx_q, 2'b00});
    endcase
  end

  fcs_bus_master #(.AW(BUS_AW), .DW(32)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_we    (cmd_we),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .bus_rdata (bus_rdata)
  );

  assign accept       = (state_q == ST_IDLE) && start;
  assign ctrl_issue   = (state_q == ST_CTRL) && cmd_valid;
  assign poll_fail    = (state_q == ST_POLL) && rsp_valid && !rsp_data[0];
  assign timeout      = poll_fail && (poll_q == PC_W'(POLL_LIMIT - 1));
  assign last_word    = (word_idx_q + WC_W'(1) == word_cnt);
  assign chunk_retire = (state_q == ST_EMIT) && emit_drain && last_word;

  assign emit_load  = (state_q == ST_DATA) && rsp_valid;
  assign emit_n     = is_words ? NW'(BYTES_PER_WORD) : NW'(chunk_sz);
  assign emit_final = (rem_q == chunk_sz) && last_word;

  fcs_byte_emit #(.DW(32)) u_emit (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (emit_load),
    .load_word  (rsp_data),
    .load_n     (emit_n),
    .load_final (emit_final),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_last   (out_last),
    .drain      (emit_drain)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cmd_sent_q <= 1'b0;
      addr_q     <= '0;
      rem_q      <= '0;
      word_idx_q <= '0;
      poll_q     <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (cmd_valid) cmd_sent_q <= 1'b1;
      if (rsp_valid) cmd_sent_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            err_q  <= 1'b0;
            addr_q <= req_addr;
            rem_q  <= req_count;
            if (req_count == '0) done_q  <= 1'b1;
            else                 state_q <= ST_CTRL;
          end
        end
        ST_CTRL: begin
          if (rsp_valid) begin
            poll_q  <= '0;
            state_q <= ST_POLL;
          end
        end
        ST_POLL: begin
          if (rsp_valid) begin
            if (rsp_data[0]) begin
              word_idx_q <= '0;
              state_q    <= ST_DATA;
            end else if (timeout) begin
              err_q   <= 1'b1;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              poll_q <= poll_q + PC_W'(1);
            end
          end
        end
        ST_DATA: begin
          if (rsp_valid) state_q <= ST_EMIT;
        end
        ST_EMIT: begin
          if (emit_drain) begin
            if (!last_word) begin
              word_idx_q <= word_idx_q + WC_W'(1);
              state_q    <= ST_DATA;
            end else begin
              addr_q <= addr_q + ADDR_W'(chunk_sz);
              rem_q  <= rem_q - chunk_sz;
              if (rem_q == chunk_sz) begin
                done_q  <= 1'b1;
                state_q <= ST_IDLE;
              end else begin
                state_q <= ST_CTRL;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;
  assign err  = err_q;

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
  parameter int CNT_W     = 10,
  parameter int BUS_AW    = 8,
  parameter int CHUNK_MAX = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              bus_req,
  input logic              bus_we,
  input logic              bus_ack,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              out_valid,
  input logic              out_last,
  input logic              ctrl_issue,
  input logic              chunk_retire,
  input logic [CNT_W-1:0]  chunk_sz,
  input logic [CNT_W-1:0]  rem_q
);

  p_chunk_fits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_issue |-> (chunk_sz != '0) && (chunk_sz <= rem_q) && (chunk_sz <= CNT_W'(CHUNK_MAX)));

  p_ctrl_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we |-> bus_wdata[0]);

  p_rem_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_retire |=> rem_q == $past(rem_q) - $past(chunk_sz));

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we));

  p_last_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  p_err_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !busy && done);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req && !out_valid);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind fuse_chunk_seq fcs_checker #(
  .CNT_W(CNT_W), .BUS_AW(BUS_AW), .CHUNK_MAX(CHUNK_MAX)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .done         (done),
  .err          (err),
  .bus_req      (bus_req),
  .bus_we       (bus_we),
  .bus_ack      (bus_ack),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .out_valid    (out_valid),
  .out_last     (out_last),
  .ctrl_issue   (ctrl_issue),
  .chunk_retire (chunk_retire),
  .chunk_sz     (chunk_sz),
  .rem_q        (rem_q)
);

// File: tb/tb_fuse_chunk_seq.sv
`timescale 1ns/1ps
module tb_fuse_chunk_seq;
  localparam int ADDR_W = 9, CNT_W = 10, BUS_AW = 8, POLL_LIMIT = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [CNT_W-1:0] req_count = '0;
  logic busy, done, err, bus_req, bus_we, out_valid, out_last;
  logic [BUS_AW-1:0] bus_addr;
  logic [31:0] bus_wdata;
  logic bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic [7:0] out_data;

  fuse_chunk_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BUS_AW(BUS_AW), .POLL_LIMIT(POLL_LIMIT)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_addr(req_addr), .req_count(req_count),
    .busy(busy), .done(done), .err(err), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last));

  int n_vec = 0, n_bad = 0;

  // controller model bookkeeping
  int ctrl_n, tmo_chunk, polls_left, data_idx, cur_a, cur_l, wait_left, req_cycles;
  int ctrl_addr [64], ctrl_len [64], ctrl_en [64], stat_n [64], data_n [64];
  bit order_bad, stray;
  // stream capture
  int byte_q [600];
  int nbytes, last_n, last_at;

  function automatic int fbyte(int a);
    return ((a * 29) + (a >> 3) ^ 8'h5A) & 8'hFF;
  endfunction

  function automatic int exp_chunk(int left);
    if (left >= 32) return 32;
    if (left >= 4)  return left - (left % 4);
    return left;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    ctrl_n = 0; order_bad = 0; stray = 0; req_cycles = 0;
    nbytes = 0; last_n = 0; last_at = -1;
    for (int i = 0; i < 64; i++) begin
      ctrl_addr[i] = 0; ctrl_len[i] = 0; ctrl_en[i] = 0; stat_n[i] = 0; data_n[i] = 0;
    end
  endtask

  // controller responder, acts on falling edges
  initial begin
    wait_left = 0;
    forever begin
      @(negedge clk);
      if (bus_ack) begin
        bus_ack = 1'b0;
      end else if (bus_req) begin
        if (wait_left > 0) wait_left--;
        else begin
          if (bus_we && bus_addr == 8'h00) begin
            if (ctrl_n < 64) begin
              ctrl_addr[ctrl_n] = int'(bus_wdata[29:21]);
              ctrl_len[ctrl_n]  = int'(bus_wdata[20:16]) + 1;
              ctrl_en[ctrl_n]   = int'(bus_wdata[0]);
            end
            cur_a = int'(bus_wdata[29:21]);
            cur_l = int'(bus_wdata[20:16]) + 1;
            polls_left = (ctrl_n == tmo_chunk) ? 1000 : int'($urandom % 4);
            data_idx = 0;
            ctrl_n++;
          end else if (!bus_we && bus_addr == 8'h04 && ctrl_n > 0) begin
            stat_n[ctrl_n-1]++;
            bus_rdata = 32'hABCD_0000 | ((polls_left == 0) ? 32'd1 : 32'd0);
            if (polls_left > 0) polls_left--;
          end else if (!bus_we && bus_addr >= 8'h08 && ctrl_n > 0) begin
            int idx;
            idx = (int'(bus_addr) - 8) / 4;
            if (idx != data_idx) order_bad = 1;
            data_idx++;
            data_n[ctrl_n-1]++;
            for (int j = 0; j < 4; j++)
              bus_rdata[8*j +: 8] = (4*idx + j < cur_l) ? 8'(fbyte(cur_a + 4*idx + j)) : 8'hEE;
          end else begin
            stray = 1;
          end
          bus_ack = 1'b1;
          wait_left = int'($urandom % 3);
        end
      end
    end
  end

  // stream and bus monitor
  initial forever begin
    @(negedge clk);
    if (bus_req) req_cycles++;
    if (out_valid) begin
      if (nbytes < 600) byte_q[nbytes] = int'(out_data);
      if (out_last) begin last_n++; last_at = nbytes; end
      nbytes++;
    end
  end

  task automatic run_req(int a, int c, int tmo, bit poke);
    int cyc, ea, er, k, expb, sz;
    bit timed;
    clear_log();
    tmo_chunk = tmo;
    @(negedge clk);
    start = 1'b1; req_addr = ADDR_W'(a); req_count = CNT_W'(c);
    @(negedge clk);
    start = 1'b0;
    if (c != 0) chk(err == 1'b0, "R12 err cleared on accept", int'(err), 0);
    cyc = 0;
    while (!done && cyc < 30000) begin
      if (poke && cyc == 5) begin
        start = 1'b1; req_addr = ADDR_W'(a ^ 9'h55); req_count = CNT_W'(7);
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(done == 1'b1, "R3 request finished", int'(done), 1);
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && bus_req == 1'b0, "R8/R9 idle after done", int'(busy), 0);
    if (c == 0) begin
      chk(cyc == 0, "R10 zero count done latency", cyc, 0);
      chk(req_cycles == 0 && nbytes == 0, "R10 zero count no traffic", req_cycles + nbytes, 0);
      return;
    end
    ea = a; er = c; k = 0; expb = 0; timed = 0;
    while (er > 0) begin
      sz = exp_chunk(er);
      chk(ctrl_addr[k] == ea, "R2 ctrl address field", ctrl_addr[k], ea);
      chk(ctrl_len[k] == sz, "R1 piece size in length field", ctrl_len[k], sz);
      chk(ctrl_en[k] == 1, "R2 enable bit", ctrl_en[k], 1);
      if (k == tmo) begin
        timed = 1;
        chk(stat_n[k] == POLL_LIMIT, "R4 poll count at timeout", stat_n[k], POLL_LIMIT);
        chk(data_n[k] == 0, "R8 no data reads after timeout", data_n[k], 0);
        break;
      end
      chk(data_n[k] == ((sz % 4 == 0) ? sz / 4 : 1), "R5 data word reads", data_n[k],
          (sz % 4 == 0) ? sz / 4 : 1);
      expb += sz; ea += sz; er -= sz; k++;
    end
    chk(ctrl_n == k + int'(timed), "R3 number of pieces", ctrl_n, k + int'(timed));
    chk(nbytes == expb, "R3 byte total", nbytes, expb);
    chk(!order_bad && !stray, "R5 word order and offsets", int'(order_bad) + int'(stray), 0);
    for (int i = 0; i < expb && i < 600; i++)
      chk(byte_q[i] == fbyte(a + i), "R6 byte value", byte_q[i], fbyte(a + i));
    if (timed) chk(last_n == 0, "R7 no last on timeout", last_n, 0);
    else chk(last_n == 1 && last_at == c - 1, "R7 last on final byte", last_at, c - 1);
    chk(err == timed, "R8 err flag", int'(err), int'(timed));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int a, c;
    void'($urandom(32'h1F5E));
    tmo_chunk = -1;
    clear_log();
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && err == 0, "R11 reset status", int'(busy) + int'(done) + int'(err), 0);
    chk(bus_req == 0 && out_valid == 0, "R11 reset bus/stream", int'(bus_req) + int'(out_valid), 0);
    rst_n = 1'b1;
    run_req(12, 0, -1, 0);
    run_req(5, 3, -1, 0);
    run_req(0, 32, -1, 0);
    run_req(7, 31, -1, 0);
    run_req(100, 36, -1, 0);
    run_req(3, 1, -1, 0);
    run_req(2, 2, -1, 0);
    run_req(0, 4, -1, 0);
    run_req(480, 32, -1, 0);
    run_req(10, 100, 2, 0);
    run_req(40, 20, -1, 0);
    run_req(0, 3, 0, 0);
    run_req(1, 6, -1, 0);
    run_req(20, 64, -1, 1);
    run_req(9, 0, -1, 0);
    for (int n = 0; n < 30; n++) begin
      c = int'($urandom % 160);
      a = int'($urandom % (512 - c));
      run_req(a, c, ((n % 7) == 3) ? int'($urandom % 3) : -1, (n % 5) == 1);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule